// File: doc/BRIEF.md
# Peak-Current Switch Sequencer

This block drives the two power switches of a synchronous buck stage that runs under peak current mode control. It works on a fast system clock. It samples four asynchronous inputs:

- a switching reference clock;
- the output of an analog current-threshold comparator;
- an active-low shutdown input;
- an undervoltage-lockout flag.

From these it produces the high-side gate, the low-side gate, a flag telling the output stage to float its pin, and a reset strobe for the slope-compensation ramp.

A falling edge of the reference clock starts each switching period. The low side first holds for a programmable minimum-off count. After a one-cycle break-before-make gap, the high side turns on for a programmable minimum-on count, and the comparator is ignored during that count. The high side then stays on until the comparator trips. The low side takes over and holds until the next falling reference edge, so conduction never stops while the block is enabled. Every switch handover passes through one cycle in which both gates are low.

The comparator, current sensing, error amplifier and analog gate drivers sit outside the block. All four inputs pass through a synchronizer of `SYNC_LEN` stages before any logic uses them. Both minimum counts are read live, so they should only change while the block is idle.

Top module: `pcm_switch_seq`

## Requirements
- R1: While reset is held and right after it, both gates are low, `out_hiz_o` is high and `ramp_rst_o` is low.
- R2: Switching takes place only while `shdn_n_i` is high and `uvlo_i` is low. Within `SYNC_LEN`+1 cycles of either condition failing, both gates go low and `out_hiz_o` goes high, and they stay that way whatever the reference and the comparator do.
- R3: A falling reference edge that reaches the sequencer while it is enabled starts a period. The low gate is high from `SYNC_LEN`+1 cycles after the edge is driven, and it stays on for max(`t_min_off_i`,1) cycles before the high side can start.
- R4: After the minimum-off count, both gates are low for exactly one cycle. The high gate is then on for at least max(`t_min_on_i`,1) cycles, and the comparator has no effect during that count.
- R5: Once the minimum-on count has passed, the high gate turns off `SYNC_LEN`+1 cycles after the comparator rises. If the comparator was raised k cycles after the high gate rose, the high pulse lasts max(max(`t_min_on_i`,1), k+`SYNC_LEN`+1) cycles.
- R6: After a comparator trip, the low gate comes on after a one-cycle gap. It stays on through the next falling reference edge and then for a further fresh minimum-off count, with no cycle off in between. This makes the low pulse length m+`SYNC_LEN`+1+max(`t_min_off_i`,1), where the edge was driven m cycles after the low gate rose.
- R7: A falling reference edge that arrives while the high gate is on ends the high pulse, even inside the minimum-on count. It is followed by a one-cycle gap and a full minimum-off low pulse.
- R8: The two gates are never high in the same cycle, and either gate rises only after a cycle in which the other was low.
- R9: `ramp_rst_o` is high in exactly the cycles in which the low gate is high.
- R10: A minimum count of 0 behaves like a count of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_clk_i | input | 1 | Switching reference clock; its falling edge starts a period |
| cmp_trip_i | input | 1 | Current-threshold comparator, high when the peak is reached |
| shdn_n_i | input | 1 | Low: shutdown; high: release |
| uvlo_i | input | 1 | High while the input supply is below its lockout level |
| t_min_on_i | input | CNT_W | Minimum high-side on time in system-clock cycles |
| t_min_off_i | input | CNT_W | Minimum low-side on time in system-clock cycles |
| hs_gate_o | output | 1 | High-side switch gate |
| ls_gate_o | output | 1 | Low-side switch gate |
| out_hiz_o | output | 1 | Output stage floats its pin (idle, switches off) |
| ramp_rst_o | output | 1 | Slope-compensation ramp reset |

## Verification
Every input reaches the state register `SYNC_LEN`+1 cycles after it is driven, which is three cycles by default. Each pulse length is therefore a fixed sum: the minimum counts plus that latency plus the number of cycles the stimulus waited after an observed gate edge.

The driver waits on the falling clock edge until it sees a gate rise. It then waits a known number of falling edges before it moves the reference or the comparator, and it queues the pulse lengths that R3 to R7 predict. The monitor measures every run of a constant gate pattern on falling edges, so each run's length is compared after the run is complete. The latency of the first low pulse is also sampled directly, on the third falling edge after the reference edge.

// File: rtl/pcm_seq_pkg.sv
package pcm_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LS_MIN,
    ST_LS_HOLD,
    ST_GAP_HS,
    ST_HS_MIN,
    ST_HS_WAIT,
    ST_GAP_LS_MIN,
    ST_GAP_LS_HOLD
  } seq_state_e;
endpackage

// File: rtl/pcm_in_sync.sv
module pcm_in_sync #(
  parameter int             WIDTH   = 4,
  parameter int             STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/pcm_edge_fall.sv
module pcm_edge_fall (
  input  logic clk,
  input  logic rst_n,
  input  logic sig,
  output logic fall
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sig;
  end

  assign fall = prev_q & ~sig;
endmodule

// File: rtl/pcm_min_timer.sv
module pcm_min_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [CNT_W-1:0] limit,
  output logic             done
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim_m1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (clr)            cnt_q <= '0;
    else if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
  end

  // a zero limit behaves as one cycle
  assign lim_m1 = (limit == '0) ? '0 : limit - 1'b1;
  assign done   = (cnt_q >= lim_m1);
endmodule

// File: rtl/pcm_phase_fsm.sv
module pcm_phase_fsm
  import pcm_seq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic fall,
  input  logic trip,
  input  logic tmr_done,
  output logic restart,
  output logic sel_on,
  output logic hs_on,
  output logic ls_on,
  output logic idle
);
  seq_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (!enable) begin
      state_d = ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE:        if (fall) state_d = ST_LS_MIN;
        ST_LS_MIN:      if (fall) state_d = ST_LS_MIN;
                        else if (tmr_done) state_d = ST_GAP_HS;
        ST_LS_HOLD:     if (fall) state_d = ST_LS_MIN;
        ST_GAP_HS:      state_d = fall ? ST_LS_MIN : ST_HS_MIN;
        ST_HS_MIN:      if (fall) state_d = ST_GAP_LS_MIN;
                        else if (tmr_done) state_d = trip ? ST_GAP_LS_HOLD : ST_HS_WAIT;
        ST_HS_WAIT:     if (fall) state_d = ST_GAP_LS_MIN;
                        else if (trip) state_d = ST_GAP_LS_HOLD;
        ST_GAP_LS_MIN:  state_d = ST_LS_MIN;
        ST_GAP_LS_HOLD: state_d = fall ? ST_LS_MIN : ST_LS_HOLD;
        default:        state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  // every state entry, and every reference edge, restarts the interval count
  assign restart = (state_d != state_q) | fall;
  assign sel_on  = (state_q == ST_HS_MIN);
  assign hs_on   = (state_q == ST_HS_MIN) | (state_q == ST_HS_WAIT);
  assign ls_on   = (state_q == ST_LS_MIN) | (state_q == ST_LS_HOLD);
  assign idle    = (state_q == ST_IDLE);
endmodule

// File: rtl/pcm_switch_seq.sv
module pcm_switch_seq #(
  parameter int CNT_W    = 8,
  parameter int SYNC_LEN = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_clk_i,
  input  logic             cmp_trip_i,
  input  logic             shdn_n_i,
  input  logic             uvlo_i,
  input  logic [CNT_W-1:0] t_min_on_i,
  input  logic [CNT_W-1:0] t_min_off_i,
  output logic             hs_gate_o,
  output logic             ls_gate_o,
  output logic             out_hiz_o,
  output logic             ramp_rst_o
);
  localparam int          N_IN    = 4;
  // bit order {uvlo, shdn_n, cmp, ref}; lockout asserted until proven clear
  localparam logic [N_IN-1:0] SYNC_RST = 4'b1000;

  logic [N_IN-1:0] raw_in, syn_in;
  logic ref_s, cmp_s, shdn_n_s, uvlo_s;
  logic fall, enable, restart, sel_on, tmr_done;
  logic hs_on, ls_on, idle;
  logic [CNT_W-1:0] limit;

  assign raw_in = {uvlo_i, shdn_n_i, cmp_trip_i, ref_clk_i};

  pcm_in_sync #(.WIDTH(N_IN), .STAGES(SYNC_LEN), .RST_VAL(SYNC_RST)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_in), .q(syn_in)
  );

  assign {uvlo_s, shdn_n_s, cmp_s, ref_s} = syn_in;
  assign enable = shdn_n_s & ~uvlo_s;

  pcm_edge_fall u_edge (
    .clk(clk), .rst_n(rst_n), .sig(ref_s), .fall(fall)
  );

  assign limit = sel_on ? t_min_on_i : t_min_off_i;

  pcm_min_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .clr(restart), .limit(limit), .done(tmr_done)
  );

  pcm_phase_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .enable(enable), .fall(fall), .trip(cmp_s),
    .tmr_done(tmr_done), .restart(restart), .sel_on(sel_on),
    .hs_on(hs_on), .ls_on(ls_on), .idle(idle)
  );

  assign hs_gate_o  = hs_on;
  assign ls_gate_o  = ls_on;
  assign out_hiz_o  = idle;
  assign ramp_rst_o = ls_on;
endmodule

// File: rtl/pcm_switch_seq_chk.sv
module pcm_switch_seq_chk #(
  parameter int CNT_W    = 8,
  parameter int SYNC_LEN = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             shdn_n_i,
  input logic             uvlo_i,
  input logic [CNT_W-1:0] t_min_off_i,
  input logic             hs_gate_o,
  input logic             ls_gate_o,
  input logic             out_hiz_o
);
  localparam int LAT = SYNC_LEN + 1;
  localparam int DW  = $clog2(LAT + 1);
  localparam logic [CNT_W:0] RUN_MAX = '1;

  logic [DW-1:0]  dis_cnt;
  logic [CNT_W:0] ls_run, ls_last, off_min;
  logic           dis;

  assign dis     = !shdn_n_i || uvlo_i;
  assign off_min = (t_min_off_i == '0) ? (CNT_W+1)'(1) : {1'b0, t_min_off_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dis_cnt <= '0;
      ls_run  <= '0;
      ls_last <= '0;
    end else begin
      if (!dis) dis_cnt <= '0;
      else if (dis_cnt != DW'(LAT)) dis_cnt <= dis_cnt + 1'b1;
      if (ls_gate_o) begin
        if (ls_run != RUN_MAX) ls_run <= ls_run + 1'b1;
      end else begin
        ls_run <= '0;
        if (ls_run != '0) ls_last <= ls_run;
      end
    end
  end

  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_gate_o && ls_gate_o)); // R8
  AST_HS_AFTER_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_gate_o) |-> !$past(ls_gate_o)); // R8
  AST_LS_AFTER_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ls_gate_o) |-> !$past(hs_gate_o)); // R8
  AST_HIZ_GATES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    out_hiz_o |-> (!hs_gate_o && !ls_gate_o)); // R2
  AST_DISABLED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (dis_cnt == DW'(LAT)) |-> out_hiz_o); // R2
  AST_MIN_OFF_BEFORE_HS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_gate_o) |-> (ls_last >= off_min)); // R3
endmodule

bind pcm_switch_seq pcm_switch_seq_chk #(.CNT_W(CNT_W), .SYNC_LEN(SYNC_LEN)) i_chk (
  .clk(clk), .rst_n(rst_n), .shdn_n_i(shdn_n_i), .uvlo_i(uvlo_i),
  .t_min_off_i(t_min_off_i), .hs_gate_o(hs_gate_o), .ls_gate_o(ls_gate_o),
  .out_hiz_o(out_hiz_o)
);

// File: tb/test_pcm_switch_seq.sv
`timescale 1ns/1ps
module test_pcm_switch_seq;
  localparam int CNT_W = 8;
  localparam int LAT   = 3;  // SYNC_LEN + 1 with defaults

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_clk = 1'b1, cmp = 1'b0, shdn_n = 1'b0, uvlo = 1'b0;
  logic [CNT_W-1:0] t_on = 8'd5, t_off = 8'd4;
  logic hs, ls, hiz, ramp;

  always #2.5 clk = ~clk;

  pcm_switch_seq i_pcm_switch_seq (
    .clk(clk), .rst_n(rst_n), .ref_clk_i(ref_clk), .cmp_trip_i(cmp),
    .shdn_n_i(shdn_n), .uvlo_i(uvlo), .t_min_on_i(t_on), .t_min_off_i(t_off),
    .hs_gate_o(hs), .ls_gate_o(ls), .out_hiz_o(hiz), .ramp_rst_o(ramp)
  );

  typedef struct { logic [2:0] vec; int len; string req; } item_t;
  item_t exp_q[$];
  int checks = 0, errors = 0;
  bit mon_en = 0, finished = 0;

  localparam logic [2:0] V_LS = 3'b001, V_HS = 3'b010, V_GAP = 3'b000, V_HIZ = 3'b100;

  function automatic int eff(input logic [CNT_W-1:0] v);
    return (v == 0) ? 1 : int'(v);
  endfunction

  task automatic push(input logic [2:0] v, input int n, input string r);
    item_t it;
    it.vec = v; it.len = n; it.req = r;
    exp_q.push_back(it);
  endtask

  task automatic check(input bit ok, input string r, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", r, act, expv);
    end
  endtask

  // monitor: measures runs of constant gate pattern, pops expectations
  logic [2:0] prev_vec = V_HIZ;
  int run_len = 0;
  always @(negedge clk) begin
    if (mon_en) begin
      logic [2:0] v;
      v = {hiz, hs, ls};
      check(ramp == ls, "R9 ramp follows low gate", ramp, ls);
      check(!(hs && ls), "R8 gates exclusive", {hs, ls}, 0);
      if (v != prev_vec) begin
        if (prev_vec != V_HIZ) begin
          if (exp_q.size() == 0) begin
            check(0, "unexpected run", int'(prev_vec), -1);
          end else begin
            item_t it;
            it = exp_q.pop_front();
            check(it.vec == prev_vec && it.len == run_len,
                  $sformatf("%s pattern %0d/%0d len", it.req, prev_vec, it.vec),
                  run_len, it.len);
          end
        end
        prev_vec = v;
        run_len = 1;
      end else begin
        run_len++;
      end
    end
  end

  task automatic wait_hs;
    @(negedge clk);
    while (!hs) @(negedge clk);
  endtask

  task automatic wait_ls;
    @(negedge clk);
    while (!ls) @(negedge clk);
  endtask

  task automatic ref_fall;
    ref_clk = 1'b0;
    repeat (4) @(negedge clk);
    ref_clk = 1'b1;
  endtask

  // high pulse ended by comparator raised k cycles after the rise (R4, R5)
  task automatic hs_by_trip(input int k, input string r);
    int n;
    n = (k + LAT > eff(t_on)) ? k + LAT : eff(t_on);
    push(V_HS, n, r);
    push(V_GAP, 1, "R8");
    wait_hs();
    repeat (k) @(negedge clk);
    cmp = 1'b1;
    while (hs) @(negedge clk);
    cmp = 1'b0;
  endtask

  // low pulse after a trip, ended m cycles later by a reference edge (R6)
  task automatic ls_until_fall(input int m);
    push(V_LS, m + LAT + eff(t_off), "R6");
    push(V_GAP, 1, "R8");
    wait_ls();
    repeat (m) @(negedge clk);
    ref_fall();
  endtask

  initial begin
    repeat (4) @(negedge clk);
    check(!hs && !ls && hiz && !ramp, "R1 reset outputs", {hiz, hs, ls, ramp}, 4'b1000);
    rst_n = 1'b1;
    @(negedge clk);
    check(!hs && !ls && hiz && !ramp, "R1 after reset", {hiz, hs, ls, ramp}, 4'b1000);
    mon_en = 1;

    shdn_n = 1'b1;
    repeat (8) @(negedge clk);
    check(hiz && !ls, "R3 idle waits for edge", {hiz, ls}, 2'b10);

    // first period from idle: latency check on the low gate
    push(V_LS, eff(t_off), "R3");
    push(V_GAP, 1, "R4");
    ref_clk = 1'b0;
    repeat (2) @(negedge clk);
    check(!ls, "R3 low gate not before latency", ls, 0);
    @(negedge clk);
    check(ls && !hiz, "R3 low gate at latency", ls, 1);
    repeat (2) @(negedge clk);
    ref_clk = 1'b1;

    hs_by_trip(6, "R5 late trip");
    ls_until_fall(5);
    hs_by_trip(0, "R4 trip ignored in min-on");
    ls_until_fall(0);

    // reference edge cuts high pulse inside min-on (R7)
    push(V_HS, 1 + LAT, "R7");
    push(V_GAP, 1, "R8");
    push(V_LS, eff(t_off), "R7");
    push(V_GAP, 1, "R8");
    wait_hs();
    repeat (1) @(negedge clk);
    ref_fall();

    hs_by_trip(2, "R5 trip at min-on end");

    // lockout during the low hold (R2)
    push(V_LS, 2 + LAT, "R2");
    wait_ls();
    repeat (2) @(negedge clk);
    uvlo = 1'b1;
    repeat (6) @(negedge clk);
    check(hiz && !hs && !ls, "R2 lockout idles", {hiz, hs, ls}, 3'b100);
    ref_fall();
    cmp = 1'b1;
    repeat (8) @(negedge clk);
    check(hiz && !hs && !ls, "R2 edges ignored in lockout", {hiz, hs, ls}, 3'b100);
    cmp = 1'b0;

    // zero minimum counts act as one (R10)
    t_on = 8'd0;
    t_off = 8'd0;
    uvlo = 1'b0;
    repeat (5) @(negedge clk);
    push(V_LS, 1, "R10");
    push(V_GAP, 1, "R8");
    ref_fall();
    hs_by_trip(0, "R10 min-on zero");
    ls_until_fall(0);
    hs_by_trip(1, "R5 short min-on");
    ls_until_fall(1);

    // shutdown during the high pulse (R2)
    push(V_HS, 2 + LAT, "R2");
    wait_hs();
    repeat (2) @(negedge clk);
    shdn_n = 1'b0;
    repeat (6) @(negedge clk);
    check(hiz && !hs && !ls, "R2 shutdown floats output", {hiz, hs, ls}, 3'b100);

    repeat (10) @(negedge clk);
    check(exp_q.size() == 0, "all expected runs seen", exp_q.size(), 0);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule